// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year counted from a base year of 1970, which gives the years 1970 to 2069. It advances once per second on a one-cycle `tick` strobe. That strobe comes from a 32768 Hz timebase, which is divided and synchronized into `clk` outside the block. Day-of-month limits follow the month. February takes its length from a leap flag that is stored beside the year.

A small register bus reads every field and writes the time as one group. Field writes land in a staging copy. Setting the trigger bit arms a commit, and the next second tick loads all seven staged fields into the running counters at once. A control bit selects whether hours read back in 24-hour form or in 12-hour form with a PM bit. Reading the seconds field also captures the other six fields. Later reads of those fields return the captured values, so the software sees one consistent instant even when a second boundary falls between its reads.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the clock reads 00:00:00, weekday 0, day 01, month 01, year 00 with the leap flag clear, 12-hour read format, and no commit pending.
- R2: Each tick without a pending commit advances seconds by one BCD step, and 59 wraps to 00 with a carry into minutes. Without a tick no field changes.
- R3: Minutes wrap from 59 to 00 with a carry into hours, and hours wrap from 23 to 00 with a carry into the day.
- R4: On every day rollover the weekday increments modulo 7 (6 wraps to 0).
- R5: The day of month wraps to 01 after 30 in April, June, September and November, and after 31 in the other months. In February it wraps after 29 when the leap flag is set and after 28 otherwise. Month wraps from 12 to 01 with a carry into the year.
- R6: Year wraps from 99 to 00. On each year increment the leap flag is recomputed as set when (year + 1970) is divisible by 4.
- R7: Writes to addresses 0 to 6 change only the staged copy. The running time is unchanged until a commit. The commit tick loads the staged values exactly, without also incrementing.
- R8: Writing address 7 with bit 15 set arms a commit, and bit 15 of address 7 reads 1 while it is armed. The first tick after the arming write loads the staged time and clears the bit. A trigger write in the same cycle as a tick waits for the following tick.
- R9: Address 8 bit 0 selects the hour read format. 1 gives the 24-hour BCD value 00 to 23. 0 gives 12-hour form: bit 5 is PM and bits 4:0 hold BCD 01 to 12, with 00 reading as 12 AM and 12 as 12 PM. Hours are always written in 24-hour form.
- R10: A read of seconds (address 0) captures the other six fields. Reads of addresses 1 to 6 return the captured values even if ticks have occurred since.
- R11: Read data appears on `rdata`, with `rd_valid` high, in the cycle after `rd_en`. Register map: 0 seconds [6:0], 1 minutes [6:0], 2 hours [5:0], 3 weekday [2:0], 4 day [5:0], 5 month [4:0], 6 year [7:0] with the leap flag at bit 15, 7 trigger at bit 15, 8 control at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle once-per-second strobe, already in the clk domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High in the cycle `rdata` holds a read result |

## Verification
Two cases can fall in the same cycle. In the first, a trigger write and a second tick share a clock edge: the bench drives both strobes in one cycle and expects the trigger bit to stay set, the seconds to advance normally, and the staged time to load only on the next tick. In the second, a second boundary falls between reads of one snapshot: the bench reads seconds at 10:59:59, ticks into the next hour, and expects the minute and hour reads to still show 59 and 10 before a fresh read shows 11:00:00. A monitor compares every read result against a queue of expected words that is filled from hand-derived calendar values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       leap;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] mday;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{leap: 1'b0, year: 8'h00, mon: 5'h01,
                                 mday: 6'h01, wday: 3'd0, hour: 6'h00,
                                 min: 7'h00, sec: 7'h00};

  localparam int A_SEC  = 0;
  localparam int A_MIN  = 1;
  localparam int A_HOUR = 2;
  localparam int A_WDAY = 3;
  localparam int A_MDAY = 4;
  localparam int A_MON  = 5;
  localparam int A_YEAR = 6;
  localparam int A_TRIG = 7;
  localparam int A_CTRL = 8;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic int bcd_to_int(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] int_to_bcd(input int n);
    return {4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [5:0] hour_to_12(input logic [5:0] h);
    int         b;
    int         d;
    logic [7:0] t;
    b = bcd_to_int({2'b00, h});
    d = (b == 0) ? 12 : ((b > 12) ? b - 12 : b);
    t = int_to_bcd(d);
    return {(b >= 12), t[4:0]};
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 1970
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  cal_t load_val,
  output cal_t now
);
  localparam int LEAP_OFS = BASE_YEAR % 4;

  cal_t       nxt;
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] s_sec, s_min, s_hr, s_md, s_mo, s_yr;
  int         yr_bin;

  always_comb begin
    s_sec  = bcd_step({1'b0, now.sec});
    s_min  = bcd_step({1'b0, now.min});
    s_hr   = bcd_step({2'b00, now.hour});
    s_md   = bcd_step({2'b00, now.mday});
    s_mo   = bcd_step({3'b000, now.mon});
    s_yr   = bcd_step(now.year);
    c_min  = (now.sec == 7'h59);
    c_hr   = c_min && (now.min == 7'h59);
    c_day  = c_hr && (now.hour == 6'h23);
    c_mon  = c_day && (now.mday == month_len(now.mon, now.leap));
    c_yr   = c_mon && (now.mon == 5'h12);
    nxt    = now;
    nxt.sec = c_min ? 7'h00 : s_sec[6:0];
    if (c_min) nxt.min  = c_hr  ? 7'h00 : s_min[6:0];
    if (c_hr)  nxt.hour = c_day ? 6'h00 : s_hr[5:0];
    if (c_day) begin
      nxt.wday = (now.wday >= 3'd6) ? 3'd0 : now.wday + 3'd1;
      nxt.mday = c_mon ? 6'h01 : s_md[5:0];
    end
    if (c_mon) nxt.mon = c_yr ? 5'h01 : s_mo[4:0];
    if (c_yr)  nxt.year = (now.year == 8'h99) ? 8'h00 : s_yr;
    yr_bin = bcd_to_int(nxt.year);
    if (c_yr)  nxt.leap = (((yr_bin + LEAP_OFS) % 4) == 0);
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= CAL_RESET;
    else if (tick) now <= load ? load_val : nxt;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.sec == 7'h59) |=> (now.sec == 7'h00));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && load) |=> (now == $past(load_val)));

  // R4
  wday_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.wday == 3'd6 && now.sec == 7'h59 && now.min == 7'h59
     && now.hour == 6'h23) |=> (now.wday == 3'd0));
endmodule

// File: rtl/rtc_stage.sv
module rtc_stage
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cal_t              staged,
  output logic              pending,
  output logic              mode24
);
  localparam int FLAG = DATA_W - 1;

  logic arm;
  assign arm = wr_en && (addr == ADDR_W'(A_TRIG)) && wdata[FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      staged  <= CAL_RESET;
      pending <= 1'b0;
      mode24  <= 1'b0;
    end else begin
      if (arm)       pending <= 1'b1;
      else if (tick) pending <= 1'b0;
      if (wr_en) begin
        case (addr)
          ADDR_W'(A_SEC):  staged.sec  <= wdata[6:0];
          ADDR_W'(A_MIN):  staged.min  <= wdata[6:0];
          ADDR_W'(A_HOUR): staged.hour <= wdata[5:0];
          ADDR_W'(A_WDAY): staged.wday <= wdata[2:0];
          ADDR_W'(A_MDAY): staged.mday <= wdata[5:0];
          ADDR_W'(A_MON):  staged.mon  <= wdata[4:0];
          ADDR_W'(A_YEAR): begin
            staged.year <= wdata[7:0];
            staged.leap <= wdata[FLAG];
          end
          ADDR_W'(A_CTRL): mode24 <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && pending && !arm) |=> !pending);

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> pending);

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(staged));
endmodule

// File: rtl/rtc_readout.sv
module rtc_readout
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              now,
  input  logic              pending,
  input  logic              mode24,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int FLAG = DATA_W - 1;

  cal_t              snap;
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (addr)
      ADDR_W'(A_SEC):  word[6:0] = now.sec;
      ADDR_W'(A_MIN):  word[6:0] = snap.min;
      ADDR_W'(A_HOUR): word[5:0] = mode24 ? snap.hour : hour_to_12(snap.hour);
      ADDR_W'(A_WDAY): word[2:0] = snap.wday;
      ADDR_W'(A_MDAY): word[5:0] = snap.mday;
      ADDR_W'(A_MON):  word[4:0] = snap.mon;
      ADDR_W'(A_YEAR): begin
        word[7:0]  = snap.year;
        word[FLAG] = snap.leap;
      end
      ADDR_W'(A_TRIG): word[FLAG] = pending;
      ADDR_W'(A_CTRL): word[0] = mode24;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
      snap     <= CAL_RESET;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rdata <= word;
        if (addr == ADDR_W'(A_SEC)) snap <= now;
      end
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == ADDR_W'(A_SEC)) |=> $stable(snap));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int BASE_YEAR = 1970
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  cal_t staged;
  cal_t now;
  logic pending;
  logic mode24;

  rtc_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .staged(staged), .pending(pending), .mode24(mode24)
  );

  rtc_calendar #(.BASE_YEAR(BASE_YEAR)) u_cal (
    .clk(clk), .rst(rst), .tick(tick), .load(pending),
    .load_val(staged), .now(now)
  );

  rtc_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .now(now),
    .pending(pending), .mode24(mode24), .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bcd_rtc_core dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  // monitor: pops expected words as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      logic [15:0] e;
      string       t;
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R11 unexpected read data %h", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errs++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic stage_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                            input logic [15:0] y);
    wr(4'd0, {8'h00, s}); wr(4'd1, {8'h00, m}); wr(4'd2, {8'h00, h});
    wr(4'd3, {8'h00, w}); wr(4'd4, {8'h00, d}); wr(4'd5, {8'h00, mo});
    wr(4'd6, y);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                          input logic [15:0] y);
    stage_time(s, m, h, w, d, mo, y);
    wr(4'd7, 16'h8000);
    tk();
  endtask

  task automatic expect_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                             input logic [15:0] y, input string t);
    rd(4'd0, {8'h00, s}, {t, " sec"});
    rd(4'd1, {8'h00, m}, {t, " min"});
    rd(4'd2, {8'h00, h}, {t, " hour"});
    rd(4'd3, {8'h00, w}, {t, " wday"});
    rd(4'd4, {8'h00, d}, {t, " mday"});
    rd(4'd5, {8'h00, mo}, {t, " mon"});
    rd(4'd6, y, {t, " year"});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state (12-hour read: 00 reads as 12 AM)
    expect_time(8'h00, 8'h00, 8'h12, 8'h0, 8'h01, 8'h01, 16'h0000, "R1 reset");
    rd(4'd7, 16'h0000, "R1 trigger idle");
    rd(4'd8, 16'h0000, "R1 ctrl");

    // R9 switch to 24-hour reads
    wr(4'd8, 16'h0001);
    rd(4'd8, 16'h0001, "R9 ctrl readback");
    rd(4'd0, 16'h0000, "R9 sec latch");
    rd(4'd2, 16'h0000, "R9 hour 24h");

    // R7/R8 staging and commit, leap February
    stage_time(8'h58, 8'h59, 8'h23, 8'h6, 8'h28, 8'h02, 16'h8030);
    wr(4'd7, 16'h8000);
    rd(4'd7, 16'h8000, "R8 armed");
    rd(4'd0, 16'h0000, "R7 no effect before commit");
    tk();
    rd(4'd7, 16'h0000, "R8 self clear");
    expect_time(8'h58, 8'h59, 8'h23, 8'h6, 8'h28, 8'h02, 16'h8030, "R7 R11 commit");
    tk();
    rd(4'd0, 16'h0059, "R2 step");
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h0, 8'h29, 8'h02, 16'h8030, "R2 R3 R4 R5 leap feb");

    set_time(8'h59, 8'h59, 8'h23, 8'h0, 8'h29, 8'h02, 16'h8030);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h1, 8'h01, 8'h03, 16'h8030, "R5 feb29 end");

    set_time(8'h59, 8'h59, 8'h23, 8'h2, 8'h28, 8'h02, 16'h0031);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h3, 8'h01, 8'h03, 16'h0031, "R5 feb28 end");

    set_time(8'h59, 8'h59, 8'h23, 8'h3, 8'h30, 8'h04, 16'h0031);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h4, 8'h01, 8'h05, 16'h0031, "R5 30-day");

    set_time(8'h59, 8'h59, 8'h23, 8'h5, 8'h31, 8'h01, 16'h0031);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h6, 8'h01, 8'h02, 16'h0031, "R5 31-day");

    set_time(8'h59, 8'h59, 8'h23, 8'h6, 8'h31, 8'h12, 16'h0099);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h0, 8'h01, 8'h01, 16'h0000, "R6 R4 R5 year wrap");

    set_time(8'h59, 8'h59, 8'h23, 8'h0, 8'h31, 8'h12, 16'h0029);
    tk();
    expect_time(8'h00, 8'h00, 8'h00, 8'h1, 8'h01, 8'h01, 16'h8030, "R6 leap set");

    // R10 snapshot across a tick, R3 hour carry
    set_time(8'h59, 8'h59, 8'h10, 8'h1, 8'h15, 8'h06, 16'h0045);
    rd(4'd0, 16'h0059, "R10 sec latch");
    tk();
    rd(4'd1, 16'h0059, "R10 min snapshot");
    rd(4'd2, 16'h0010, "R10 hour snapshot");
    expect_time(8'h00, 8'h00, 8'h11, 8'h1, 8'h15, 8'h06, 16'h0045, "R3 hour carry");

    // R7 write without trigger is ignored by the running time
    wr(4'd0, 16'h0033);
    tk();
    expect_time(8'h01, 8'h00, 8'h11, 8'h1, 8'h15, 8'h06, 16'h0045, "R7 unstaged");

    // R8 trigger in the same cycle as a tick
    @(negedge clk); wr_en = 1'b1; addr = 4'd7; wdata = 16'h8000; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(4'd7, 16'h8000, "R8 same-cycle still armed");
    rd(4'd0, 16'h0002, "R8 same-cycle tick counted");
    tk();
    rd(4'd7, 16'h0000, "R8 cleared");
    expect_time(8'h33, 8'h59, 8'h10, 8'h1, 8'h15, 8'h06, 16'h0045, "R8 delayed commit");

    // R9 12-hour reads
    wr(4'd8, 16'h0000);
    set_time(8'h00, 8'h00, 8'h13, 8'h1, 8'h15, 8'h06, 16'h0045);
    rd(4'd0, 16'h0000, "R9 latch");
    rd(4'd2, 16'h0021, "R9 13h as 1 PM");
    set_time(8'h59, 8'h59, 8'h11, 8'h1, 8'h15, 8'h06, 16'h0045);
    rd(4'd0, 16'h0059, "R9 latch");
    rd(4'd2, 16'h0011, "R9 11 AM");
    tk();
    rd(4'd0, 16'h0000, "R9 latch");
    rd(4'd2, 16'h0032, "R9 noon as 12 PM");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errs++; checks++;
      $display("FAIL R11 missing %0d read results (actual=%0d expected=0)", exp_q.size(), exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired (actual=running expected=finished)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule